// File: doc/BRIEF.md
# Multi-Channel Peripheral-Bus DMA Engine

This block is a small DMA engine with several identical channels that copy data element by element between a memory-side bus and a peripheral-side bus. Both sides are reached through one shared request/ready access port. A select output on that port says which bus each access targets. Each channel is programmed through four word registers: source address, destination address, cycle count and command. The command word holds the transfer setup, the run bit, two interrupt enables and two sticky status flags.

Software loads the addresses and the count, then writes the command word with the run bit set. A cycle moves one element of 1, 2 or 4 bytes, or four elements in burst mode. When a side names a nonzero request number, each cycle waits until that request line is high. A channel stops by itself when its count runs out or when the access port reports an error. All channels drive one shared interrupt output. Software scans the status flags to find the cause and clears a flag by writing the command word back with that flag at zero.

Top module: `pbdma_top`

## Requirements
- R1: Channel c has its registers at byte offset 0x80 + 16*c: source address at +0, destination address at +4, cycle count at +8, command at +12. All of them read as zero after reset, and the interrupt and access request are low after reset.
- R2: Command word bit layout: bit 0 run, bit 1 finish interrupt enable, bit 2 error interrupt enable, bit 3 finish status, bit 4 error status, bit 5 burst, bits 7:6 width code, bit 8 source on peripheral bus, bit 9 destination on peripheral bus, bit 10 source increment, bit 11 destination increment, bits 15:12 source request number, bits 19:16 destination request number. Bits 31:20 read as zero.
- R3: Each element is a read at the source address followed by a write of the same data word to the destination address. mem_size carries the width code (0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes, with 3 driven as 2).
- R4: In burst mode each counted cycle moves four elements. Without burst it moves one. The count drops by one per completed cycle.
- R5: An address whose increment bit is set advances by the element size after each element, and an address whose bit is clear stays fixed. mem_periph equals the source-side select bit during reads and the destination-side select bit during writes.
- R6: A nonzero source or destination request number n makes each cycle wait until dreq[n] is high. A request number of 0 means no wait.
- R7: When the count reaches zero, the channel clears its run bit and sets finish status. A channel started with a count of zero finishes without any access.
- R8: An error response on an access sets error status and clears the run bit. The channel then stops, with no further access and no decrement of the count.
- R9: A command write clears a status bit written as 0, leaves a status bit written as 1 unchanged (it cannot set it), and loads every other field from the written value.
- R10: irq is high exactly when some channel has (finish status and finish enable) or (error status and error enable).
- R11: Only one channel uses the access port at a time. A channel keeps the port for a whole cycle. When several channels are ready, the lowest index wins. A request holds its address and direction until ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| dreq | input | 16 | Peripheral request lines |
| mem_req | output | 1 | Access request |
| mem_we | output | 1 | Access is a write |
| mem_periph | output | 1 | Access targets the peripheral bus |
| mem_addr | output | 32 | Access byte address |
| mem_size | output | 2 | Element size code |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| mem_rdy | input | 1 | Access completes this cycle |
| mem_err | input | 1 | Completing access has failed |
| irq | output | 1 | Shared interrupt |

## Verification
The hardest situation to reach is contention: two channels ready on the very same cycle, so that fixed priority and the whole-cycle hold of the port both show in the write order. The bench parks two channels on one request line that is held low, enables both, then raises the line so both become eligible together. Error aborts mid-transfer are reached by pointing a source address at the one location where the bench's memory model answers with an error. Stalls are reached by letting the model withhold ready on alternate cycles.

// File: rtl/pbdma_pkg.sv
// Shared constants and types for the peripheral-bus DMA engine.
// Assumes 32-bit addresses and data and 16 request lines.
package pbdma_pkg;
    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 32;
    localparam int REQ_LINES = 16;
    localparam int REQ_W     = $clog2(REQ_LINES);

    // Command word, least significant field last (run is bit 0).
    typedef struct packed {
        logic [REQ_W-1:0] drq;
        logic [REQ_W-1:0] srq;
        logic             dinc;
        logic             sinc;
        logic             dper;
        logic             sper;
        logic [1:0]       wid;
        logic             burst;
        logic             est;
        logic             fst;
        logic             eie;
        logic             fie;
        logic             en;
    } cmd_t;

    localparam int CMD_W = $bits(cmd_t);

    typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} seq_t;

    // Element size in bytes for a width code.
    function automatic logic [2:0] elem_bytes(input logic [1:0] wid);
        case (wid)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/pbdma_arb.sv
// Access port arbiter: grants the lowest-index ready channel, and only
// while no channel is busy. A busy channel keeps the port for its cycle.
module pbdma_arb #(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0] want,
    input  logic [NCH-1:0] busy,
    output logic [NCH-1:0] gnt
);
    // Isolate the lowest set request bit when the port is free.
    always_comb begin
        gnt = (|busy) ? '0 : (want & (~want + 1'b1));
    end
endmodule

// File: rtl/pbdma_chan.sv
// One DMA channel: its register set and its transfer sequencer.
// Assumes m_rdy/m_err are already qualified to this channel by the top.
module pbdma_chan
    import pbdma_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_idx,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [REQ_LINES-1:0] dreq,
    input  logic                 gnt,
    output logic                 want,
    output logic                 busy,
    output logic [ADDR_W-1:0]    src_q,
    output logic [ADDR_W-1:0]    dst_q,
    output logic [CNT_W-1:0]     cnt_q,
    output cmd_t                 cmd_q,
    output logic                 m_we,
    output logic                 m_per,
    output logic [ADDR_W-1:0]    m_addr,
    output logic [1:0]           m_size,
    output logic [DATA_W-1:0]    m_wdata,
    input  logic [DATA_W-1:0]    m_rdata,
    input  logic                 m_rdy,
    input  logic                 m_err,
    output logic                 irq
);
    seq_t              st_q;
    logic [1:0]        beat_q;
    logic [DATA_W-1:0] buf_q;
    logic [ADDR_W-1:0] step;
    logic              pace_ok, last_beat, elem_done, fin_set, err_set;
    cmd_t              wcmd;

    // Derived control terms for this cycle.
    always_comb begin
        wcmd      = cmd_t'(wr_data[CMD_W-1:0]);
        step      = {{(ADDR_W-3){1'b0}}, elem_bytes(cmd_q.wid)};
        pace_ok   = (cmd_q.srq == '0 || dreq[cmd_q.srq]) &&
                    (cmd_q.drq == '0 || dreq[cmd_q.drq]);
        last_beat = !cmd_q.burst || beat_q == 2'd3;
        elem_done = st_q == ST_WR && m_rdy && !m_err;
        err_set   = st_q != ST_IDLE && m_rdy && m_err;
        fin_set   = (st_q == ST_IDLE && cmd_q.en && cnt_q == '0) ||
                    (elem_done && last_beat && cnt_q == CNT_W'(1));
        want      = st_q == ST_IDLE && cmd_q.en && cnt_q != '0 && pace_ok;
        busy      = st_q != ST_IDLE;
    end

    // Register file: software writes win, hardware advances and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
            cnt_q <= '0;
            cmd_q <= '0;
        end else begin
            if (wr_en && wr_idx == 2'd0)      src_q <= wr_data[ADDR_W-1:0];
            else if (elem_done && cmd_q.sinc) src_q <= src_q + step;
            if (wr_en && wr_idx == 2'd1)      dst_q <= wr_data[ADDR_W-1:0];
            else if (elem_done && cmd_q.dinc) dst_q <= dst_q + step;
            if (wr_en && wr_idx == 2'd2)      cnt_q <= wr_data[CNT_W-1:0];
            else if (elem_done && last_beat)  cnt_q <= cnt_q - 1'b1;
            if (wr_en && wr_idx == 2'd3) begin
                cmd_q     <= wcmd;
                cmd_q.fst <= (cmd_q.fst & wcmd.fst) | fin_set;
                cmd_q.est <= (cmd_q.est & wcmd.est) | err_set;
            end else begin
                if (fin_set || err_set) cmd_q.en  <= 1'b0;
                if (fin_set)            cmd_q.fst <= 1'b1;
                if (err_set)            cmd_q.est <= 1'b1;
            end
        end
    end

    // Sequencer: read an element, write it, repeat for burst beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            beat_q <= '0;
            buf_q  <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (want && gnt) begin
                    st_q   <= ST_RD;
                    beat_q <= '0;
                end
                ST_RD: if (m_rdy) begin
                    st_q  <= m_err ? ST_IDLE : ST_WR;
                    buf_q <= m_rdata;
                end
                ST_WR: if (m_rdy) begin
                    if (m_err || last_beat) st_q <= ST_IDLE;
                    else begin
                        st_q   <= ST_RD;
                        beat_q <= beat_q + 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Access port drive and the channel's interrupt term.
    always_comb begin
        m_we    = st_q == ST_WR;
        m_per   = m_we ? cmd_q.dper : cmd_q.sper;
        m_addr  = m_we ? dst_q : src_q;
        m_size  = (cmd_q.wid == 2'd3) ? 2'd2 : cmd_q.wid;
        m_wdata = buf_q;
        irq     = (cmd_q.fst && cmd_q.fie) || (cmd_q.est && cmd_q.eie);
    end
endmodule

// File: rtl/pbdma_top.sv
// Multi-channel DMA top: register decode, channel array, access port
// mux and shared interrupt. Assumes word-aligned register accesses.
module pbdma_top
    import pbdma_pkg::*;
#(
    parameter int          NCH      = 4,
    parameter int          CNT_W    = 16,
    parameter int          REG_AW   = 8,
    parameter logic [7:0]  REG_BASE = 8'h80
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [REQ_LINES-1:0] dreq,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic                 mem_periph,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [1:0]           mem_size,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic [DATA_W-1:0]    mem_rdata,
    input  logic                 mem_rdy,
    input  logic                 mem_err,
    output logic                 irq
);
    localparam int SLOT_W = REG_AW - 4;

    logic [REG_AW-1:0] off;
    logic [SLOT_W-1:0] slot;
    logic [1:0]        ridx;
    logic              in_win;
    logic              unused_lsb;
    logic [NCH-1:0]    sel, want_v, busy_v, gnt_v, irq_v, fin_v, err_v;
    logic [NCH-1:0]    we_a, per_a;
    logic [ADDR_W-1:0] src_a [NCH];
    logic [ADDR_W-1:0] dst_a [NCH];
    logic [ADDR_W-1:0] addr_a [NCH];
    logic [DATA_W-1:0] wd_a [NCH];
    logic [CNT_W-1:0]  cnt_a [NCH];
    logic [1:0]        size_a [NCH];
    cmd_t              cmd_a [NCH];

    // Split the register address into channel slot and word index.
    always_comb begin
        off        = reg_addr - REG_BASE;
        in_win     = reg_addr >= REG_BASE;
        slot       = off[REG_AW-1:4];
        ridx       = off[3:2];
        unused_lsb = &{1'b0, off[1:0]};
    end

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            assign sel[c]   = in_win && slot == SLOT_W'(c);
            assign fin_v[c] = cmd_a[c].fst;
            assign err_v[c] = cmd_a[c].est;
            pbdma_chan #(.CNT_W(CNT_W)) u_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (reg_we && sel[c]),
                .wr_idx  (ridx),
                .wr_data (reg_wdata),
                .dreq    (dreq),
                .gnt     (gnt_v[c]),
                .want    (want_v[c]),
                .busy    (busy_v[c]),
                .src_q   (src_a[c]),
                .dst_q   (dst_a[c]),
                .cnt_q   (cnt_a[c]),
                .cmd_q   (cmd_a[c]),
                .m_we    (we_a[c]),
                .m_per   (per_a[c]),
                .m_addr  (addr_a[c]),
                .m_size  (size_a[c]),
                .m_wdata (wd_a[c]),
                .m_rdata (mem_rdata),
                .m_rdy   (mem_rdy && busy_v[c]),
                .m_err   (mem_err),
                .irq     (irq_v[c])
            );
        end
    endgenerate

    pbdma_arb #(.NCH(NCH)) u_arb (
        .want (want_v),
        .busy (busy_v),
        .gnt  (gnt_v)
    );

    // Register readback mux.
    always_comb begin
        reg_rdata = '0;
        for (int c = 0; c < NCH; c++) begin
            if (sel[c]) begin
                case (ridx)
                    2'd0: reg_rdata = src_a[c];
                    2'd1: reg_rdata = dst_a[c];
                    2'd2: reg_rdata = {{(DATA_W-CNT_W){1'b0}}, cnt_a[c]};
                    default: reg_rdata = {{(DATA_W-CMD_W){1'b0}}, cmd_a[c]};
                endcase
            end
        end
    end

    // AND-OR mux of the single busy channel onto the access port.
    always_comb begin
        mem_req    = |busy_v;
        mem_we     = 1'b0;
        mem_periph = 1'b0;
        mem_addr   = '0;
        mem_size   = '0;
        mem_wdata  = '0;
        for (int c = 0; c < NCH; c++) begin
            mem_we     = mem_we     | (busy_v[c] & we_a[c]);
            mem_periph = mem_periph | (busy_v[c] & per_a[c]);
            mem_addr   = mem_addr   | ({ADDR_W{busy_v[c]}} & addr_a[c]);
            mem_size   = mem_size   | ({2{busy_v[c]}} & size_a[c]);
            mem_wdata  = mem_wdata  | ({DATA_W{busy_v[c]}} & wd_a[c]);
        end
    end

    // Shared interrupt.
    assign irq = |irq_v;
endmodule

// File: rtl/pbdma_chk.sv
// Protocol and status checks for pbdma_top, attached by bind.
module pbdma_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           mem_req,
    input logic           mem_we,
    input logic           mem_rdy,
    input logic           mem_err,
    input logic [31:0]    mem_addr,
    input logic           irq,
    input logic [NCH-1:0] busy,
    input logic [NCH-1:0] fin_v,
    input logic [NCH-1:0] err_v
);
    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(busy)); // R11

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rdy |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R11

    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_rdy && !mem_we && !mem_err |=> mem_req && mem_we); // R3

    AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_rdy && mem_err |=> !mem_req && (err_v != '0)); // R8

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (fin_v | err_v) != '0); // R10
endmodule

bind pbdma_top pbdma_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_rdy  (mem_rdy),
    .mem_err  (mem_err),
    .mem_addr (mem_addr),
    .irq      (irq),
    .busy     (busy_v),
    .fin_v    (fin_v),
    .err_v    (err_v)
);

// File: tb/sim_pbdma_top.sv
module sim_pbdma_top;
    localparam int NCH = 4;
    localparam logic [31:0] ERR_ADDR = 32'h0000_0EE0;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic [15:0] dreq = '0;
    logic        mem_req, mem_we, mem_periph, mem_rdy, mem_err, irq;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;
    logic        rdy_en = 1'b1, stall = 1'b0;
    int          nchk = 0, nerr = 0, nw = 0, nrd = 0;
    logic [31:0] wl_addr [64];
    logic [31:0] wl_data [64];
    logic        wl_per  [64];
    logic [1:0]  wl_size [64];

    pbdma_top #(.NCH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_periph(mem_periph),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_rdy(mem_rdy), .mem_err(mem_err), .irq(irq)
    );

    always #10 clk = ~clk;

    // Memory model: data is a function of address and bus.
    function automatic logic [31:0] pat(input logic [31:0] a, input logic p);
        return a ^ (p ? 32'hC3C3_0000 : 32'h5A5A_0000);
    endfunction
    assign mem_rdy   = mem_req && rdy_en;
    assign mem_err   = mem_req && mem_addr == ERR_ADDR;
    assign mem_rdata = pat(mem_addr, mem_periph);

    always @(negedge clk) rdy_en <= stall ? ~rdy_en : 1'b1;

    always @(posedge clk) begin
        if (rst_n && mem_req && mem_rdy && !mem_err) begin
            if (mem_we) begin
                if (nw < 64) begin
                    wl_addr[nw] <= mem_addr;
                    wl_data[nw] <= mem_wdata;
                    wl_per[nw]  <= mem_periph;
                    wl_size[nw] <= mem_size;
                end
                nw <= nw + 1;
            end else nrd <= nrd + 1;
        end
    end

    typedef struct packed {
        logic [1:0]  wid;
        logic        burst, sinc, dinc, sper, dper;
        logic [7:0]  cnt;
        logic [15:0] src, dst;
    } vec_t;

    localparam vec_t VT [5] = '{
        '{2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd3, 16'h0100, 16'h0200},
        '{2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd2, 16'h0300, 16'h0040},
        '{2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd2, 16'h0400, 16'h0500},
        '{2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd3, 16'h0060, 16'h0600},
        '{2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd1, 16'h0700, 16'h0800}
    };

    localparam logic [31:0] FST = 32'h8, EST = 32'h10;

    // Command word per the R2 layout.
    function automatic logic [31:0] mk_cmd(input logic en, fie, eie, burst,
        input logic [1:0] wid, input logic sper, dper, sinc, dinc,
        input logic [3:0] srq, drq);
        return {12'b0, drq, srq, dinc, sinc, dper, sper, wid, burst, 2'b00, eie, fie, en};
    endfunction

    function automatic logic [7:0] ra(input int ch, input int idx);
        return 8'(8'h80 + ch * 16 + idx * 4);
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_irq(input string tag);
        int t = 0;
        while (!irq && t < 3000) begin
            @(negedge clk);
            t++;
        end
        if (!irq) chk(tag, 32'(irq), 32'd1);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL R11 watchdog expired got=hung exp=done");
        finish_run();
    end

    initial begin
        logic [31:0] d, exp;
        int ch, n, st, b, idx;
        vec_t v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every register and outputs.
        for (int c = 0; c < NCH; c++)
            for (int i = 0; i < 4; i++) begin
                rd(ra(c, i), d);
                chk("R1 reset register", d, 32'h0);
            end
        chk("R1 reset irq", 32'(irq), 32'h0);
        chk("R1 reset mem_req", 32'(mem_req), 32'h0);

        // Table walk: main copy function over widths, burst, increments, buses.
        for (int k = 0; k < 5; k++) begin
            v = VT[k];
            ch = k % NCH;
            n = int'(v.cnt) * (v.burst ? 4 : 1);
            st = (v.wid == 2'd0) ? 1 : ((v.wid == 2'd1) ? 2 : 4);
            b = nw;
            stall = k[0];
            exp = mk_cmd(1'b1, 1'b1, 1'b1, v.burst, v.wid, v.sper, v.dper,
                         v.sinc, v.dinc, 4'd0, 4'd0);
            wr(ra(ch, 0), {16'h0, v.src});
            wr(ra(ch, 1), {16'h0, v.dst});
            wr(ra(ch, 2), {24'h0, v.cnt});
            wr(ra(ch, 3), exp);
            wait_irq("R7 finish irq");
            stall = 1'b0;
            chk("R4 element count", 32'(nw - b), 32'(n));
            for (int e = 0; e < n; e++) begin
                idx = b + e;
                chk("R3 write data", wl_data[idx],
                    pat(32'(v.src) + (v.sinc ? 32'(e * st) : 32'h0), v.sper));
                chk("R5 write address", wl_addr[idx],
                    32'(v.dst) + (v.dinc ? 32'(e * st) : 32'h0));
                chk("R5 write bus select", 32'(wl_per[idx]), 32'(v.dper));
                chk("R3 size code", 32'(wl_size[idx]), (v.wid == 2'd3) ? 32'd2 : 32'(v.wid));
            end
            rd(ra(ch, 0), d);
            chk("R5 final source", d, 32'(v.src) + (v.sinc ? 32'(n * st) : 32'h0));
            rd(ra(ch, 1), d);
            chk("R5 final destination", d, 32'(v.dst) + (v.dinc ? 32'(n * st) : 32'h0));
            rd(ra(ch, 2), d);
            chk("R7 count at zero", d, 32'h0);
            rd(ra(ch, 3), d);
            chk("R7 run cleared, finish set", d, (exp & ~32'h1) | FST);
            wr(ra(ch, 3), d & ~FST);
            rd(ra(ch, 3), d);
            chk("R9 finish cleared, fields kept", d, exp & ~32'h1);
            chk("R10 irq low after clear", 32'(irq), 32'h0);
        end

        // R6: paced source waits on its request line.
        b = nw;
        wr(ra(1, 0), 32'h0000_0900);
        wr(ra(1, 1), 32'h0000_0980);
        wr(ra(1, 2), 32'd1);
        wr(ra(1, 3), mk_cmd(1'b1, 1'b1, 1'b0, 1'b0, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 4'd5, 4'd0));
        repeat (20) @(negedge clk);
        chk("R6 no access while request low", 32'(mem_req), 32'h0);
        chk("R6 no write while request low", 32'(nw - b), 32'h0);
        rd(ra(1, 2), d);
        chk("R6 count untouched while waiting", d, 32'd1);
        dreq[5] = 1'b1;
        wait_irq("R6 finish after request");
        chk("R6 one write after request", 32'(nw - b), 32'd1);
        dreq = '0;
        wr(ra(1, 3), 32'h0);

        // R7: zero count finishes at once, no access.
        b = nw; n = nrd;
        wr(ra(2, 2), 32'd0);
        wr(ra(2, 3), mk_cmd(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd0, 4'd0));
        repeat (2) @(negedge clk);
        rd(ra(2, 3), d);
        chk("R7 zero count finish", d & 32'h9, FST);
        chk("R7 zero count no access", 32'((nw - b) + (nrd - n)), 32'h0);
        chk("R10 irq on finish", 32'(irq), 32'h1);
        wr(ra(2, 3), 32'h0);

        // R8: error response aborts.
        b = nw;
        exp = mk_cmd(1'b1, 1'b0, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 4'd0, 4'd0);
        wr(ra(3, 0), ERR_ADDR);
        wr(ra(3, 1), 32'h0000_0A80);
        wr(ra(3, 2), 32'd2);
        wr(ra(3, 3), exp);
        wait_irq("R8 error irq");
        repeat (5) @(negedge clk);
        rd(ra(3, 3), d);
        chk("R8 error set, run cleared", d, (exp & ~32'h1) | EST);
        rd(ra(3, 2), d);
        chk("R8 count not decremented", d, 32'd2);
        rd(ra(3, 0), d);
        chk("R8 source not advanced", d, ERR_ADDR);
        chk("R8 no write after error", 32'(nw - b), 32'h0);
        // R10: status without enable does not interrupt.
        wr(ra(3, 3), ((exp & ~32'h1) | EST) & ~32'h4);
        chk("R10 no irq with enable off", 32'(irq), 32'h0);
        rd(ra(3, 3), d);
        chk("R9 error kept when written as one", d & EST, EST);
        wr(ra(3, 3), 32'h0);
        rd(ra(3, 3), d);
        chk("R9 error cleared when written as zero", d, 32'h0);

        // R9: writing one to a status bit does not set it.
        wr(ra(0, 3), FST | EST | 32'h6);
        rd(ra(0, 3), d);
        chk("R9 status not set by write", d, 32'h6);
        wr(ra(0, 3), 32'h0);

        // R11: two channels ready together; lowest index first, whole cycles.
        b = nw;
        wr(ra(0, 0), 32'h0000_0C00); wr(ra(0, 1), 32'h0000_0A00); wr(ra(0, 2), 32'd2);
        wr(ra(2, 0), 32'h0000_0D00); wr(ra(2, 1), 32'h0000_0B00); wr(ra(2, 2), 32'd2);
        wr(ra(2, 3), mk_cmd(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd7, 4'd0));
        wr(ra(0, 3), mk_cmd(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd7, 4'd0));
        repeat (3) @(negedge clk);
        dreq[7] = 1'b1;
        wait_irq("R11 second channel finish");
        chk("R11 total writes", 32'(nw - b), 32'd4);
        chk("R11 first write from channel 0", wl_addr[b], 32'h0000_0A00);
        chk("R11 second write from channel 0", wl_addr[b + 1], 32'h0000_0A01);
        chk("R11 third write from channel 2", wl_addr[b + 2], 32'h0000_0B00);
        chk("R11 fourth write from channel 2", wl_addr[b + 3], 32'h0000_0B01);
        rd(ra(0, 3), d);
        chk("R7 channel 0 finished", d & 32'h9, FST);

        finish_run();
    end
endmodule